// File: doc/BRIEF.md
# Variable-Latency DDR Memory Link Sequencer

This block sits on the controller side of a double-data-rate memory link with a chip select, a gated differential clock, an 8-bit data bus and a bidirectional strobe. It takes one host request at a time and carries it out in phases. First it sends a 48-bit command word over three memory clocks. Next it waits out the initial latency. Last it moves write bytes out, with a per-byte mask on the strobe, or captures read bytes that the memory marks with strobe transitions. The PHY is outside the block: the bus pins appear as separate output, output-enable and input signals.

The block runs on one clock, `clk`. One `clk` cycle is one *beat*, which is half a memory clock and carries one byte. The memory clock output toggles once on each beat that moves. The latency count `cfg_lat` is in memory clocks, so a single latency is `2*cfg_lat` beats and a doubled latency is `4*cfg_lat` beats. In variable mode the memory may report a refresh collision by raising the strobe partway through the command phase. For that reason the block takes the strobe level after the second rising clock edge of the command, not at chip-select assertion. `cfg_lat` and `cfg_var_en` are static while a transaction is in flight. `cfg_lat` must be at least 1.

Host-side handshake rules:
- A request transfers on `req_valid && req_ready`. Its fields must hold steady while `req_valid` is high.
- Write bytes transfer on `wr_valid && wr_ready`. Holding `wr_valid` low stalls the link: no clock edge is sent until a byte is offered.
- Read bytes come out on `rd_valid` with no ready. The memory cannot be paused, so the consumer must take every byte.

Top module: `hbseq_top`

## Requirements
- R1: Each transaction starts with a 48-bit command word sent as six bytes, most significant byte first, one byte per beat. The memory clock is high during the first byte. Bit 47 is 1 for a read and 0 for a write. Bit 46 is 1 for register space and 0 for memory space. Bits ADDR_W-1:0 carry `req_addr`, and the bits between are zero.
- R2: With `cfg_var_en`=1, a high strobe seen during the fourth command byte makes the block wait `4*cfg_lat` beats between the command and the first data beat. The strobe level during the first two command bytes has no effect.
- R3: With `cfg_var_en`=1, a low strobe during the fourth command byte gives a wait of `2*cfg_lat` beats.
- R4: With `cfg_var_en`=0, the wait is always `4*cfg_lat` beats, whatever the strobe level.
- R5: A register-space write has no latency wait: its first data byte follows the last command byte directly. The strobe is not driven during it, so `wr_mask` has no effect.
- R6: During a memory-space write, each accepted byte goes out on one beat with the strobe driven to `wr_mask` (1 = byte masked, 0 = byte written). While `wr_valid` is low the memory clock does not toggle.
- R7: During a read, the block captures one byte from `hb_dq_i` on each strobe transition after the latency. It delivers the bytes in order on `rd_valid`/`rd_data`.
- R8: Chip select stays high for at least GAP_BEATS (default 2) cycles between transactions, and the memory clock is low whenever chip select is high.
- R9: After reset, chip select is high, the clock is low, neither the bus nor the strobe is driven, and `req_ready` is high.
- R10: A transaction moves exactly `2*(req_words+1)` data bytes, and the block accepts the next request only after chip select has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lat | input | LAT_W | Initial latency in memory clocks (at least 1) |
| cfg_var_en | input | 1 | 1 = latency chosen per transaction from the strobe, 0 = always doubled |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | 1 = register space, 0 = memory space |
| req_addr | input | ADDR_W | Target address |
| req_words | input | LEN_W | Burst length in 16-bit words, minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block is in a write data phase |
| wr_data | input | 8 | Write byte |
| wr_mask | input | 1 | 1 = leave this byte unwritten |
| rd_valid | output | 1 | Read byte present (no back-pressure) |
| rd_data | output | 8 | Read byte |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck | output | 1 | Memory clock, true phase |
| hb_ck_n | output | 1 | Memory clock, complement |
| hb_dq_o | output | 8 | Data bus output value |
| hb_dq_oe | output | 1 | Data bus output enable |
| hb_dq_i | input | 8 | Data bus input value |
| hb_rwds_o | output | 1 | Strobe output value (write mask) |
| hb_rwds_oe | output | 1 | Strobe output enable |
| hb_rwds_i | input | 1 | Strobe input value |

## Verification
The embedded properties check these rules on every cycle:
- the clock is quiet and nothing is driven while chip select is high;
- the minimum chip-select gap holds;
- the clock is held during a write stall;
- the latency wait lasts as long as the sampled strobe and the mode call for;
- fixed mode always selects the doubled wait;
- no register write passes through the wait state;
- the number of captured read bytes stays within bounds.

Only the bench's scenarios can show the rest. A strobe that changes in the middle of the command phase must be sampled at the right byte. The write data must land on exactly the beat the latency predicts, with the right mask. Read bytes must come back in order, for every mix of mode, collision and address space.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_WDAT,
    ST_RDAT,
    ST_RTAIL,
    ST_GAP
  } seq_st_t;

  localparam int CMD_BYTES   = 6;
  localparam int SAMPLE_BYTE = 3;  // fourth command byte, after the second rising edge
endpackage

// File: rtl/hbseq_lat.sv
module hbseq_lat #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_var_en,
  input  logic             sample_en,
  input  logic             rwds_i,
  input  logic             start,
  input  logic             run,
  output logic             done
);
  localparam int CNT_W = LAT_W + 2;

  logic             dbl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wait_beats;
  logic [CNT_W-1:0] run_len;

  assign wait_beats = dbl_q ? {cfg_lat, 2'b00} : {1'b0, cfg_lat, 1'b0};
  assign done       = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (sample_en) dbl_q <= !cfg_var_en || rwds_i;
      if (start) cnt_q <= wait_beats - CNT_W'(1);
      else if (run && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) run_len <= '0;
    else run_len <= run_len + CNT_W'(1);
  end

  // R2 R3: the wait ends after exactly the beat count chosen by the sampled strobe
  assert_wait_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == wait_beats - CNT_W'(1)));

  assert_fixed_dbl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_var_en) |-> dbl_q);
endmodule

// File: rtl/hbseq_rdcap.sv
module hbseq_rdcap #(
  parameter int BCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [BCNT_W-1:0] total,
  input  logic              rwds_i,
  input  logic [7:0]        dq_i,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              last
);
  logic              rwds_prev;
  logic              cap;
  logic [BCNT_W-1:0] rx_cnt;

  assign cap  = arm && (rwds_i != rwds_prev);
  assign last = cap && (rx_cnt == total - BCNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwds_prev <= 1'b0;
      rx_cnt    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rwds_prev <= rwds_i;
      rd_valid  <= cap;
      if (cap) rd_data <= dq_i;
      if (!arm) rx_cnt <= '0;
      else if (cap) rx_cnt <= rx_cnt + BCNT_W'(1);
    end
  end

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (rx_cnt < total));
endmodule

// File: rtl/hbseq_top.sv
module hbseq_top
  import hbseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int LAT_W     = 4,
  parameter int GAP_BEATS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              cfg_var_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_reg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_words,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              wr_mask,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              hb_cs_n,
  output logic              hb_ck,
  output logic              hb_ck_n,
  output logic [7:0]        hb_dq_o,
  output logic              hb_dq_oe,
  input  logic [7:0]        hb_dq_i,
  output logic              hb_rwds_o,
  output logic              hb_rwds_oe,
  input  logic              hb_rwds_i
);
  localparam int BCNT_W = LEN_W + 2;
  localparam int GAP_W  = $clog2(GAP_BEATS + 1);
  localparam int PAD_W  = 46 - ADDR_W;

  seq_st_t           st;
  logic [47:0]       cmd_q;
  logic              is_rd, is_reg;
  logic [LEN_W-1:0]  words_q;
  logic [BCNT_W-1:0] byte_cnt;
  logic [BCNT_W-1:0] total_b;
  logic [2:0]        ca_idx;
  logic              ck_q;
  logic [GAP_W-1:0]  gap_cnt;
  logic              adv;
  logic              last_beat;
  logic              lat_done;
  logic              rx_last;
  logic              reg_wr;
  logic              ca_end;
  logic [47:0]       ca_word;

  assign ca_word   = {req_read, req_reg, {PAD_W{1'b0}}, req_addr};
  assign total_b   = {({1'b0, words_q} + {{LEN_W{1'b0}}, 1'b1}), 1'b0};
  assign last_beat = (byte_cnt == total_b - BCNT_W'(1));
  assign reg_wr    = is_reg && !is_rd;
  assign ca_end    = (st == ST_CMD) && (ca_idx == 3'(CMD_BYTES - 1));

  // a beat moves unless the write path is starved
  assign adv = (st == ST_CMD) || (st == ST_WAIT) || (st == ST_RDAT) ||
               ((st == ST_WDAT) && wr_valid);

  assign hb_ck      = adv ? ~ck_q : ck_q;
  assign hb_ck_n    = ~hb_ck;
  assign hb_cs_n    = (st == ST_IDLE) || (st == ST_GAP);
  assign hb_dq_oe   = (st == ST_CMD) || (st == ST_WDAT);
  assign hb_dq_o    = (st == ST_CMD) ? cmd_q[47:40] : wr_data;
  assign hb_rwds_oe = (st == ST_WDAT) && !is_reg;
  assign hb_rwds_o  = wr_mask;
  assign req_ready  = (st == ST_IDLE);
  assign wr_ready   = (st == ST_WDAT);

  hbseq_lat #(.LAT_W(LAT_W)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lat    (cfg_lat),
    .cfg_var_en (cfg_var_en),
    .sample_en  ((st == ST_CMD) && (ca_idx == 3'(SAMPLE_BYTE))),
    .rwds_i     (hb_rwds_i),
    .start      (ca_end),
    .run        (st == ST_WAIT),
    .done       (lat_done)
  );

  hbseq_rdcap #(.BCNT_W(BCNT_W)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      ((st == ST_RDAT) || (st == ST_RTAIL)),
    .total    (total_b),
    .rwds_i   (hb_rwds_i),
    .dq_i     (hb_dq_i),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .last     (rx_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cmd_q    <= '0;
      is_rd    <= 1'b0;
      is_reg   <= 1'b0;
      words_q  <= '0;
      byte_cnt <= '0;
      ca_idx   <= '0;
      ck_q     <= 1'b0;
      gap_cnt  <= '0;
    end else begin
      ck_q <= hb_ck;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cmd_q   <= ca_word;
          is_rd   <= req_read;
          is_reg  <= req_reg;
          words_q <= req_words;
          ca_idx  <= '0;
          st      <= ST_CMD;
        end
        ST_CMD: begin
          cmd_q    <= {cmd_q[39:0], 8'h00};
          ca_idx   <= ca_idx + 3'd1;
          byte_cnt <= '0;
          if (ca_end) st <= reg_wr ? ST_WDAT : ST_WAIT;
        end
        ST_WAIT: if (lat_done) st <= is_rd ? ST_RDAT : ST_WDAT;
        ST_WDAT: if (wr_valid) begin
          byte_cnt <= byte_cnt + BCNT_W'(1);
          if (last_beat) begin
            st      <= ST_GAP;
            gap_cnt <= '0;
          end
        end
        ST_RDAT: begin
          byte_cnt <= byte_cnt + BCNT_W'(1);
          if (last_beat) begin
            st      <= rx_last ? ST_GAP : ST_RTAIL;
            gap_cnt <= '0;
          end
        end
        ST_RTAIL: if (rx_last) begin
          st      <= ST_GAP;
          gap_cnt <= '0;
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_cnt == GAP_W'(GAP_BEATS - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hb_cs_n |-> !hb_ck);

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_cs_n) |=> hb_cs_n);

  assert_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hb_cs_n |-> (!hb_dq_oe && !hb_rwds_oe));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WDAT) && !wr_valid) |-> (hb_ck == $past(hb_ck)));

  assert_reg_nowait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !reg_wr);

  assert_rd_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(st) == ST_RDAT || $past(st) == ST_RTAIL));
endmodule

// File: tb/sim_hbseq_top.sv
module sim_hbseq_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int LAT_W  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [LAT_W-1:0]  cfg_lat;
  logic              cfg_var_en;
  logic              req_valid, req_ready, req_read, req_reg;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_words;
  logic              wr_valid, wr_ready, wr_mask;
  logic [7:0]        wr_data;
  logic              rd_valid;
  logic [7:0]        rd_data;
  logic              hb_cs_n, hb_ck, hb_ck_n, hb_dq_oe, hb_rwds_o, hb_rwds_oe;
  logic [7:0]        hb_dq_o;
  logic [7:0]        hb_dq_i;
  logic              hb_rwds_i;

  hbseq_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W), .GAP_BEATS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat), .cfg_var_en(cfg_var_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_reg(req_reg), .req_addr(req_addr), .req_words(req_words),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hb_cs_n(hb_cs_n), .hb_ck(hb_ck), .hb_ck_n(hb_ck_n),
    .hb_dq_o(hb_dq_o), .hb_dq_oe(hb_dq_oe), .hb_dq_i(hb_dq_i),
    .hb_rwds_o(hb_rwds_o), .hb_rwds_oe(hb_rwds_oe), .hb_rwds_i(hb_rwds_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] rpat(input logic [ADDR_W-1:0] a, input int i);
    return a[7:0] ^ 8'(i * 37) ^ 8'h5c;
  endfunction

  function automatic logic [7:0] wpat(input logic [ADDR_W-1:0] a, input int i);
    return a[15:8] + 8'(i * 29) + 8'h13;
  endfunction

  // scoreboard queues filled by the driver
  logic [47:0] ca_q[$];
  int          lat_q[$];
  logic [8:0]  wq[$];
  logic [7:0]  rq[$];

  // memory-side model
  logic              mem_coll;
  int                mb, mlat, midx;
  logic              mprev, mpend, mlvl, mrd, mreg, mfirst;
  logic [47:0]       macc, ca_exp;
  logic [7:0]        mpbyte;
  logic [8:0]        wlog, wexp;
  logic [ADDR_W-1:0] maddr;
  int                lexp;

  always @(negedge clk) begin
    if (!rst_n || hb_cs_n) begin
      mb = 0; mprev = 1'b0; mpend = 1'b0; mlvl = 1'b0; midx = 0; mfirst = 1'b1;
      mrd = 1'b0; mreg = 1'b0; mlat = 0;
      hb_rwds_i = 1'b0; hb_dq_i = 8'h00;
    end else begin
      if (mpend) begin
        hb_dq_i = mpbyte;
        mlvl = ~mlvl;
        mpend = 1'b0;
      end
      if (hb_ck !== mprev) begin
        mprev = hb_ck;
        mb++;
        if (mb <= 6) macc = {macc[39:0], hb_dq_o};
        if (mb == 6) begin
          mrd = macc[47]; mreg = macc[46]; maddr = macc[ADDR_W-1:0];
          mlat = (!mrd && mreg) ? 0 : ((!cfg_var_en || mem_coll) ? 4 * int'(cfg_lat) : 2 * int'(cfg_lat));
          if (ca_q.size() > 0) begin
            ca_exp = ca_q.pop_front();
            chk(macc == ca_exp, "R1 command word", macc, ca_exp);
          end else chk(1'b0, "R1 unexpected command", macc, 0);
        end
        if (mb > 6) begin
          if (mrd) begin
            if (mb > 6 + mlat) begin
              mpend = 1'b1; mpbyte = rpat(maddr, midx); midx++;
            end
          end else if (hb_dq_oe) begin
            if (mfirst) begin
              mfirst = 1'b0;
              lexp = (lat_q.size() > 0) ? lat_q.pop_front() : -1;
              chk(mb == 7 + lexp, "R2 R3 R4 R5 first data beat", mb, 7 + lexp);
            end
            wlog = {hb_rwds_oe ? hb_rwds_o : 1'b0, hb_dq_o};
            if (wq.size() > 0) begin
              wexp = wq.pop_front();
              chk(wlog == wexp, "R6 write byte and mask", wlog, wexp);
            end else chk(1'b0, "R10 extra write byte", wlog, 0);
          end
        end
      end
      if (mb >= 1 && mb <= 2) hb_rwds_i = ~mem_coll;
      else if (mb >= 3 && mb <= 6) hb_rwds_i = mem_coll;
      else hb_rwds_i = mlvl;
    end
  end

  // host-side read monitor
  logic [7:0] rexp;
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rq.size() > 0) begin
        rexp = rq.pop_front();
        chk(rd_data == rexp, "R7 read byte", rd_data, rexp);
      end else chk(1'b0, "R10 extra read byte", rd_data, 0);
    end
  end

  // chip-select gap monitor
  int   hi_run;
  logic ck_bad;
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; ck_bad = 1'b0;
    end else if (hb_cs_n) begin
      hi_run++;
      if (hb_ck) ck_bad = 1'b1;
    end else if (hi_run > 0) begin
      chk(hi_run >= 2 && !ck_bad, "R8 select gap and idle clock", hi_run, 2);
      hi_run = 0; ck_bad = 1'b0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input bit rg, input logic [ADDR_W-1:0] a,
                      input int words, input bit coll, input bit stall,
                      input logic [7:0] mpat);
    int nbytes = 2 * (words + 1);
    int lat;
    int i;
    int t;
    bit stalled = 1'b0;
    lat = (!rd && rg) ? 0 : ((!cfg_var_en || coll) ? 4 * int'(cfg_lat) : 2 * int'(cfg_lat));
    mem_coll = coll;
    ca_q.push_back({rd, rg, 14'b0, a});
    if (!rd) begin
      lat_q.push_back(lat);
      for (int k = 0; k < nbytes; k++) wq.push_back({rg ? 1'b0 : mpat[k % 8], wpat(a, k)});
    end else begin
      for (int k = 0; k < nbytes; k++) rq.push_back(rpat(a, k));
    end
    req_read = rd; req_reg = rg; req_addr = a; req_words = LEN_W'(words);
    req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (!rd) begin
      i = 0; t = 0;
      while (i < nbytes && t < 1000) begin
        if (stall && i == 1 && !stalled && wr_ready) begin
          wr_valid = 1'b0; stalled = 1'b1;
        end else begin
          wr_valid = 1'b1; wr_data = wpat(a, i); wr_mask = mpat[i % 8];
        end
        #1;
        if (wr_valid && wr_ready) i++;
        @(negedge clk);
        t++;
      end
      wr_valid = 1'b0;
    end
    t = 0;
    while (!req_ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 1000) begin
      chk(1'b0, "R7 R10 transaction completion", t, 0);
      do_reset();
    end
    @(negedge clk);
    chk(rq.size() == 0 && wq.size() == 0, "R10 burst byte count", rq.size() + wq.size(), 0);
    ca_q.delete(); lat_q.delete(); wq.delete(); rq.delete();
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_lat = 4'd5; cfg_var_en = 1'b1;
    req_valid = 1'b0; req_read = 1'b0; req_reg = 1'b0; req_addr = '0; req_words = '0;
    wr_valid = 1'b0; wr_data = 8'h00; wr_mask = 1'b0; mem_coll = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(hb_cs_n == 1'b1, "R9 select high", hb_cs_n, 1);
    chk(hb_ck == 1'b0, "R9 clock low", hb_ck, 0);
    chk(!hb_dq_oe && !hb_rwds_oe, "R9 nothing driven", {hb_dq_oe, hb_rwds_oe}, 0);
    chk(req_ready == 1'b1, "R9 ready", req_ready, 1);

    // R3 write, variable mode, no collision
    xfer(1'b0, 1'b0, 32'h0000_1240, 1, 1'b0, 1'b0, 8'b0000_0110);
    // R2 write, collision reported mid-command
    xfer(1'b0, 1'b0, 32'h0003_5a10, 1, 1'b1, 1'b0, 8'b0000_1001);
    // R3 R7 read, no collision
    xfer(1'b1, 1'b0, 32'h0000_7788, 3, 1'b0, 1'b0, 8'h00);
    // R2 R7 read, collision
    xfer(1'b1, 1'b0, 32'h00ab_cd01, 2, 1'b1, 1'b0, 8'h00);
    // R4 fixed mode: doubled wait without collision
    cfg_var_en = 1'b0;
    xfer(1'b0, 1'b0, 32'h0000_0f00, 0, 1'b0, 1'b0, 8'b0000_0001);
    xfer(1'b1, 1'b0, 32'h0000_0300, 1, 1'b0, 1'b0, 8'h00);
    cfg_var_en = 1'b1;
    // R5 register write: no wait, mask ignored, collision ignored
    xfer(1'b0, 1'b1, 32'h0000_0800, 0, 1'b1, 1'b0, 8'b0000_0011);
    // register read keeps its latency
    xfer(1'b1, 1'b1, 32'h0000_0001, 0, 1'b0, 1'b0, 8'h00);
    // R6 stall on a shorter latency
    cfg_lat = 4'd3;
    xfer(1'b0, 1'b0, 32'h0000_4444, 2, 1'b0, 1'b1, 8'b1010_0101);
    xfer(1'b0, 1'b0, 32'h0000_4460, 2, 1'b1, 1'b1, 8'b0101_0000);
    // R8 back-to-back reads at minimum latency
    cfg_lat = 4'd1;
    xfer(1'b1, 1'b0, 32'h0000_9910, 0, 1'b1, 1'b0, 8'h00);
    xfer(1'b1, 1'b0, 32'h0000_9920, 0, 1'b0, 1'b0, 8'h00);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule